// File: doc/BRIEF.md
# Lockable two-stage watchdog timer

This block is a watchdog peripheral on a small register bus. A down-counter is loaded from a reload register and counts one step per clock while the watchdog runs. On the first time the count runs out, it reloads and raises an interrupt flag. If software has still not cleared that flag by the next time the count runs out, and reset escalation is enabled, the block raises a system reset request. That request stays high until the external reset arrives.

Software reads the raw interrupt flag and the flag gated by the run bit. It clears the flag through a write-to-clear register. A control bit steers the interrupt to either a standard or a non-maskable output. A lock register, released only by a 32-bit key, makes the block silently drop writes to its configuration registers. A stall bit stops the count while a debug-halt input is high.

The bus has a single write strobe. Read data is combinational on the address. All offsets are byte addresses on a 5-bit address: reload 0x00, count value 0x04 (read-only), control 0x08, flag clear 0x0C, raw status 0x10, gated status 0x14, stall 0x18, lock 0x1C.

Top module: `wdg_guard`

## Requirements
- R1: After reset, every register reads 0, the lock is released, and irqStd, irqNmi and sysResetReq are low.
- R2: Writing 1 to control bit 0 (offset 0x08) starts the watchdog and loads the counter from the reload register (0x00). While running, the count at 0x04 drops by one per clock. Control bit 0 reads back as 1 from then on, and bus writes cannot clear it.
- R3: When the running counter is at 0 on a clock edge, it reloads from the reload register at that edge and the raw flag (bit 0 of 0x10) becomes 1.
- R4: When the counter runs out while the raw flag is already 1 and control bit 1 (reset enable) is 1, sysResetReq goes high and stays high until reset. With control bit 1 at 0, sysResetReq stays low.
- R5: A reload write while the watchdog runs copies the written value into the counter at the same edge. A written value of 0 sets the raw flag at that edge.
- R6: Bit 0 of 0x14 equals the raw flag ANDed with the run bit. The selected interrupt output follows that gated value.
- R7: Writing 1 in bit 0 of 0x0C clears the raw flag, and writing 0 there leaves it unchanged. An expiry in the same cycle as a clear wins.
- R8: Control bit 2 = 0 routes the interrupt to irqStd, and 1 routes it to irqNmi. Both outputs are never high together, and in both modes the flag is cleared through 0x0C.
- R9: Writing 1ACCE551 (hex) to 0x1C releases the lock, and writing any other value engages it. Reading 0x1C returns 1 while locked and 0 otherwise.
- R10: While locked, writes to 0x00, 0x08, 0x0C and 0x18 change nothing.
- R11: With bit 0 of 0x18 set and dbgHalt high, the counter holds its value. With that bit clear, the counter keeps counting whatever the level of dbgHalt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte address of the register accessed |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| dbgHalt | input | 1 | Debug halt indication |
| irqStd | output | 1 | Standard interrupt output |
| irqNmi | output | 1 | Non-maskable interrupt output |
| sysResetReq | output | 1 | Registered system reset request |

## Verification
The counter is first run with a short reload and no interference. This fixes the exact edge at which the flag appears, and shows that a second expiry without reset enable stays silent. It is then run again with reset enable set and a short reload, which shows where the escalation happens. The count is also driven with dbgHalt high, once with the stall bit clear and once with it set. This separates the freeze from normal counting. Reload writes of a large value and of zero, clears of 0 and of 1, and the same configuration writes made before and after locking show that a locked write leaves every register as it was. A behavioural model checks every output on every cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Byte offsets of the registers
  localparam int OFF_RELOAD = 'h00;
  localparam int OFF_VALUE  = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_CLEAR  = 'h0C;
  localparam int OFF_RAW    = 'h10;
  localparam int OFF_MASKED = 'h14;
  localparam int OFF_STALL  = 'h18;
  localparam int OFF_LOCK   = 'h1C;

  // Bit positions inside the registers
  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_RSTEN_BIT = 1;
  localparam int CTRL_NMI_BIT   = 2;
  localparam int FLAG_BIT       = 0;
  localparam int STALL_BIT      = 0;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic reloadWrite;     // capture bus data into the reload register
    logic loadFromBus;     // copy bus data straight into the counter
    logic loadFromReload;  // copy the reload register into the counter
    logic countEn;         // decrement by one
  } cnt_strobe_t;

endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cnt_strobe_t       strb,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] reloadVal,
  output logic              countZero
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] reloadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (strb.reloadWrite) begin
      reloadQ <= busData;
    end
  end

  // A bus load takes priority over a reload, which takes priority over a count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.loadFromBus) begin
      countQ <= busData;
    end else if (strb.loadFromReload) begin
      countQ <= reloadQ;
    end else if (strb.countEn) begin
      countQ <= countQ - ONE;
    end
  end

  assign countVal  = countQ;
  assign reloadVal = reloadQ;
  assign countZero = (countQ == '0);

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 5,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 'h1ACCE551,
  parameter logic [DATA_W-1:0] LOCKED_CODE = 'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              dbgHalt,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] reloadVal,
  input  logic              countZero,
  output cnt_strobe_t       strb,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqStd,
  output logic              irqNmi,
  output logic              sysResetReq,
  output logic              runState,
  output logic              stallOn,
  output logic              rawFlag
);

  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFF_VALUE);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);
  localparam logic [ADDR_W-1:0] A_STALL  = ADDR_W'(OFF_STALL);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFF_LOCK);

  logic runQ, rstEnQ, nmiSelQ, stallQ, lockQ, flagQ, resetReqQ;

  // Write decode; configuration writes are gated by the lock
  logic cfgWr, hitReload, hitCtrl, hitClear, hitStall, hitLock;
  logic reloadWrRun, expiry, flagSet, flagClr, startRun;

  assign cfgWr     = regWrEn & ~lockQ;
  assign hitReload = cfgWr & (regAddr == A_RELOAD);
  assign hitCtrl   = cfgWr & (regAddr == A_CTRL);
  assign hitClear  = cfgWr & (regAddr == A_CLEAR);
  assign hitStall  = cfgWr & (regAddr == A_STALL);
  assign hitLock   = regWrEn & (regAddr == A_LOCK);

  assign reloadWrRun = hitReload & runQ;
  assign startRun    = hitCtrl & regWdata[CTRL_RUN_BIT] & ~runQ;

  always_comb begin
    strb.reloadWrite    = hitReload;
    strb.loadFromBus    = reloadWrRun;
    strb.countEn        = runQ & ~(stallQ & dbgHalt) & ~hitReload;
    expiry              = strb.countEn & countZero;
    strb.loadFromReload = expiry | startRun;
  end

  assign flagSet = expiry | (reloadWrRun & (regWdata == '0));
  assign flagClr = hitClear & regWdata[FLAG_BIT];

  // Configuration state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      rstEnQ  <= 1'b0;
      nmiSelQ <= 1'b0;
      stallQ  <= 1'b0;
      lockQ   <= 1'b0;
    end else begin
      if (hitCtrl) begin
        runQ    <= runQ | regWdata[CTRL_RUN_BIT];
        rstEnQ  <= regWdata[CTRL_RSTEN_BIT];
        nmiSelQ <= regWdata[CTRL_NMI_BIT];
      end
      if (hitStall) stallQ <= regWdata[STALL_BIT];
      if (hitLock)  lockQ  <= (regWdata != UNLOCK_KEY);
    end
  end

  // Interrupt flag and reset escalation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ     <= 1'b0;
      resetReqQ <= 1'b0;
    end else begin
      if (flagSet)      flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
      if (expiry && flagQ && rstEnQ) resetReqQ <= 1'b1;
    end
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_RELOAD: regRdata = reloadVal;
      A_VALUE:  regRdata = countVal;
      A_CTRL: begin
        regRdata[CTRL_RUN_BIT]   = runQ;
        regRdata[CTRL_RSTEN_BIT] = rstEnQ;
        regRdata[CTRL_NMI_BIT]   = nmiSelQ;
      end
      A_RAW:    regRdata[FLAG_BIT]  = flagQ;
      A_MASKED: regRdata[FLAG_BIT]  = flagQ & runQ;
      A_STALL:  regRdata[STALL_BIT] = stallQ;
      A_LOCK:   regRdata = lockQ ? LOCKED_CODE : '0;
      default:  regRdata = '0;
    endcase
  end

  assign irqStd      = flagQ & runQ & ~nmiSelQ;
  assign irqNmi      = flagQ & runQ & nmiSelQ;
  assign sysResetReq = resetReqQ;
  assign runState    = runQ;
  assign stallOn     = stallQ;
  assign rawFlag     = flagQ;

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 5,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 'h1ACCE551,
  parameter logic [DATA_W-1:0] LOCKED_CODE = 'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              dbgHalt,
  output logic              irqStd,
  output logic              irqNmi,
  output logic              sysResetReq
);

  cnt_strobe_t       strb;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] reloadVal;
  logic              countZero;
  logic              runState;
  logic              stallOn;
  logic              rawFlag;

  wdg_ctrl #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .UNLOCK_KEY (UNLOCK_KEY),
    .LOCKED_CODE(LOCKED_CODE)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .dbgHalt    (dbgHalt),
    .countVal   (countVal),
    .reloadVal  (reloadVal),
    .countZero  (countZero),
    .strb       (strb),
    .regRdata   (regRdata),
    .irqStd     (irqStd),
    .irqNmi     (irqNmi),
    .sysResetReq(sysResetReq),
    .runState   (runState),
    .stallOn    (stallOn),
    .rawFlag    (rawFlag)
  );

  wdg_datapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busData  (regWdata),
    .countVal (countVal),
    .reloadVal(reloadVal),
    .countZero(countZero)
  );

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              dbgHalt,
  input logic              irqStd,
  input logic              irqNmi,
  input logic              sysResetReq,
  input logic              runState,
  input logic              stallOn,
  input logic              rawFlag,
  input logic [DATA_W-1:0] countVal
);

  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'('h1C);
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    runState |=> runState);  // R2

  AST_DOWN_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (runState && !dbgHalt && !regWrEn && countVal != '0) |=> (countVal == $past(countVal) - ONE));  // R2

  AST_RESET_HELD: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> sysResetReq);  // R4

  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetReq) |-> $past(rawFlag));  // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (irqStd || irqNmi) |-> rawFlag);  // R6

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqStd && irqNmi));  // R8

  AST_LOCK_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == LOCK_ADDR) |-> (regRdata <= ONE));  // R9

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (dbgHalt && stallOn && !regWrEn) |=> $stable(countVal));  // R11

endmodule

bind wdg_guard wdg_guard_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regRdata   (regRdata),
  .dbgHalt    (dbgHalt),
  .irqStd     (irqStd),
  .irqNmi     (irqNmi),
  .sysResetReq(sysResetReq),
  .runState   (runState),
  .stallOn    (stallOn),
  .rawFlag    (rawFlag),
  .countVal   (countVal)
);

// File: tb/wdg_guard_tb_top.sv
module wdg_guard_tb_top;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        dbgHalt = 1'b0;
  logic [31:0] regRdata;
  logic        irqStd, irqNmi, sysResetReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdg_guard dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dbgHalt(dbgHalt),
    .irqStd(irqStd), .irqNmi(irqNmi), .sysResetReq(sysResetReq)
  );

  // Behavioural reference model
  logic [31:0] mReload = '0, mCount = '0;
  bit mRun = 0, mRstEn = 0, mNmi = 0, mStall = 0, mLocked = 0, mFlag = 0, mRst = 0;
  bit okW, relW, ticking, runOut;

  always @(posedge clk) begin
    if (!rstN) begin
      mReload = '0; mCount = '0; mRun = 0; mRstEn = 0; mNmi = 0;
      mStall = 0; mLocked = 0; mFlag = 0; mRst = 0;
    end else begin
      okW     = regWrEn && !mLocked;
      relW    = okW && regAddr == 5'h00;
      ticking = mRun && !(mStall && dbgHalt) && !relW;
      runOut  = ticking && mCount == 0;
      if (runOut && mFlag && mRstEn) mRst = 1;
      if (okW && regAddr == 5'h0C && regWdata[0]) mFlag = 0;
      if (runOut || (relW && mRun && regWdata == 0)) mFlag = 1;
      if (relW && mRun) mCount = regWdata;
      else if (runOut) mCount = mReload;
      else if (okW && regAddr == 5'h08 && regWdata[0] && !mRun) mCount = mReload;
      else if (ticking) mCount = mCount - 1;
      if (relW) mReload = regWdata;
      if (okW && regAddr == 5'h08) begin
        if (regWdata[0]) mRun = 1;
        mRstEn = regWdata[1];
        mNmi = regWdata[2];
      end
      if (okW && regAddr == 5'h18) mStall = regWdata[0];
      if (regWrEn && regAddr == 5'h1C) mLocked = (regWdata != KEY);
    end
  end

  function automatic logic [31:0] modelRead(input logic [4:0] a);
    case (a)
      5'h00: return mReload;
      5'h04: return mCount;
      5'h08: return {29'b0, mNmi, mRstEn, mRun};
      5'h10: return {31'b0, mFlag};
      5'h14: return {31'b0, mFlag & mRun};
      5'h18: return {31'b0, mStall};
      5'h1C: return mLocked ? 32'h1 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R6 irqStd vs model", {31'b0, irqStd}, {31'b0, mFlag & mRun & !mNmi});
      check("R8 irqNmi vs model", {31'b0, irqNmi}, {31'b0, mFlag & mRun & mNmi});
      check("R4 sysResetReq vs model", {31'b0, sysResetReq}, {31'b0, mRst});
      check("R3 regRdata vs model", regRdata, modelRead(regAddr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic chkRd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    regAddr = a; #1;
    check(tag, regRdata, exp);
  endtask

  task automatic pinReset();
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  logic [31:0] snap;

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      chkRd("R1 register after reset", 5'(i * 4), 32'h0);
      tick(1);
    end
    check("R1 outputs after reset", {29'b0, irqStd, irqNmi, sysResetReq}, 32'h0);

    // R2 / R3: start with reload 5 and watch the first expiry
    wr(5'h00, 32'd5);
    chkRd("R2 reload readback", 5'h00, 32'd5);
    tick(1);
    wr(5'h08, 32'h1);
    chkRd("R2 counter loaded at start", 5'h04, 32'd5);
    tick(1);
    chkRd("R2 one step per clock", 5'h04, 32'd4);
    tick(4);
    chkRd("R3 count at zero, flag still clear", 5'h04, 32'd0);
    chkRd("R3 no flag before expiry", 5'h10, 32'd0);
    tick(1);
    chkRd("R3 flag set at expiry", 5'h10, 32'd1);
    chkRd("R3 reloaded at expiry", 5'h04, 32'd5);
    chkRd("R6 gated status", 5'h14, 32'd1);
    check("R6 irqStd high", {31'b0, irqStd}, 32'd1);
    wr(5'h08, 32'h0);
    chkRd("R2 run bit not clearable", 5'h08, 32'h1);
    tick(20);
    check("R4 no reset without reset enable", {31'b0, sysResetReq}, 32'd0);

    // R5 / R7
    wr(5'h00, 32'd1000);
    chkRd("R5 running reload loads counter", 5'h04, 32'd1000);
    wr(5'h0C, 32'h0);
    chkRd("R7 clear with bit0=0 keeps flag", 5'h10, 32'd1);
    wr(5'h0C, 32'h1);
    chkRd("R7 clear with bit0=1", 5'h10, 32'd0);
    chkRd("R6 gated status after clear", 5'h14, 32'd0);
    check("R6 irqStd low after clear", {31'b0, irqStd}, 32'd0);
    wr(5'h00, 32'd0);
    chkRd("R5 zero reload sets flag", 5'h10, 32'd1);
    wr(5'h00, 32'd1000);
    wr(5'h0C, 32'h1);
    chkRd("R7 flag cleared again", 5'h10, 32'd0);

    // R11: debug halt with and without stall
    dbgHalt = 1'b1;
    regAddr = 5'h04; #1; snap = regRdata;
    tick(3);
    chkRd("R11 counts while halted without stall", 5'h04, snap - 32'd3);
    wr(5'h18, 32'h1);
    chkRd("R11 stall bit readback", 5'h18, 32'h1);
    regAddr = 5'h04; #1; snap = regRdata;
    tick(5);
    chkRd("R11 frozen while stalled and halted", 5'h04, snap);
    dbgHalt = 1'b0;
    tick(2);
    chkRd("R11 counts after halt drops", 5'h04, snap - 32'd2);
    wr(5'h18, 32'h0);

    // R8: non-maskable routing
    wr(5'h08, 32'h5);
    wr(5'h00, 32'd4);
    tick(5);
    check("R8 irqNmi high in nmi mode", {31'b0, irqNmi}, 32'd1);
    check("R8 irqStd low in nmi mode", {31'b0, irqStd}, 32'd0);
    wr(5'h0C, 32'h1);
    chkRd("R8 nmi flag cleared via clear register", 5'h10, 32'd0);
    wr(5'h00, 32'd1000);
    wr(5'h08, 32'h1);

    // R9 / R10: lock behaviour
    wr(5'h00, 32'd0);
    wr(5'h00, 32'd1000);
    wr(5'h1C, 32'h0);
    chkRd("R9 lock engaged reads 1", 5'h1C, 32'h1);
    wr(5'h08, 32'h7);
    chkRd("R10 control write ignored", 5'h08, 32'h1);
    wr(5'h00, 32'd77);
    chkRd("R10 reload write ignored", 5'h00, 32'd1000);
    wr(5'h18, 32'h1);
    chkRd("R10 stall write ignored", 5'h18, 32'h0);
    wr(5'h0C, 32'h1);
    chkRd("R10 clear write ignored", 5'h10, 32'h1);
    wr(5'h1C, KEY);
    chkRd("R9 key releases lock", 5'h1C, 32'h0);
    wr(5'h1C, 32'h1234);
    chkRd("R9 other value locks", 5'h1C, 32'h1);
    wr(5'h1C, KEY);
    chkRd("R9 released again", 5'h1C, 32'h0);

    // R4: escalation with reset enable, flag still set
    wr(5'h08, 32'h3);
    wr(5'h00, 32'd3);
    tick(3);
    check("R4 no reset before second expiry", {31'b0, sysResetReq}, 32'd0);
    tick(1);
    check("R4 reset on second expiry", {31'b0, sysResetReq}, 32'd1);
    tick(10);
    check("R4 reset request held", {31'b0, sysResetReq}, 32'd1);

    // R1: external reset clears everything
    pinReset();
    chkRd("R1 control after reset", 5'h08, 32'h0);
    chkRd("R1 lock after reset", 5'h1C, 32'h0);
    check("R1 reset request dropped", {31'b0, sysResetReq}, 32'd0);
    tick(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule